// File: doc/BRIEF.md
# Auto-Incrementing Code Memory Loader

This block fills a set of small one-bit-wide code memories, one per correlator, from a stream of 32-bit command words. Each command is either an address reset or a single-chip store. The host resets the shared write address, then issues one store command per chip in order. Each store writes the chip value at the current address of the memory picked by the command's select field, and the address then advances by itself. To load the next correlator, the host raises the select field by one, resets the address and repeats the sequence.

All memories share one write address counter. Only the selected memory receives a write strobe. A store that arrives once the counter has reached the memory depth is discarded and sets an overflow flag that stays set. Each memory also has a synchronous read port with one cycle of latency. The read ports feed a single read output, so the stored code can be checked from the same interface.

Top module: `codemem_loader`

## Requirements
- R1: After synchronous reset, `addr_count` is 0 and `overflow` is 0.
- R2: A command accepted with `cmd_valid` high and bit 28 set makes `addr_count` 0 from the next cycle and writes no memory.
- R3: A store happens only when bits 27 and 26 are both 1. A command with bit 28 clear and only one of these two bits set changes no memory and leaves `addr_count` unchanged.
- R4: A store writes bit 0 of the command at address `addr_count` of the memory numbered by bits 31:29. Presenting `rd_sel`/`rd_addr` returns the stored bit on `rd_data` one cycle later. A read in the same cycle as a store to the same location returns the value held before the store.
- R5: `addr_count` rises by exactly one after each accepted store. It keeps its value in any cycle with no accepted store or reset, including every cycle with `cmd_valid` low.
- R6: A command with bit 28 set and bits 27:26 both 1 performs the address reset only. No memory changes and `addr_count` becomes 0.
- R7: A store issued while `addr_count` equals the depth is dropped: no memory changes and `addr_count` stays at the depth. `overflow` rises the next cycle and stays 1 until reset, even across address resets.
- R8: A store writes only the selected memory. Every other memory keeps its contents.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cmd_valid | input | 1 | Command word valid strobe |
| cmd_word | input | 32 | Command: [31:29] memory select, [28] address reset, [27:26] store enable, [0] chip |
| rd_sel | input | 3 | Memory to read |
| rd_addr | input | AW | Address to read |
| rd_data | output | 1 | Bit read, one cycle after the request |
| addr_count | output | CW | Shared write address counter, 0 up to DEPTH |
| overflow | output | 1 | Sticky flag: a store arrived while the counter was at the depth |

## Verification
The first pattern is the normal load sequence: each correlator in turn, an address reset, then a full-length run of chips. It tells apart a counter that advances on every store from one that skips or repeats, and a bank select that routes correctly from one that aliases neighbouring memories.

Partial enable codes, reset-with-store commands and idle cycles show whether the enable decode needs both bits and whether a reset wins over a store. Reloading a single memory with inverted data, then sweeping all memories, exposes strobes that leak into unselected banks.

A store past the depth followed by an address reset separates a dropped, sticky overflow from one that wraps the address or clears too early. A read that hits the location being written confirms the read-first behaviour.

// File: rtl/codemem_pkg.sv
package codemem_pkg;
  localparam int CMD_W    = 32;
  localparam int SEL_W    = 3;
  localparam int SEL_LSB  = 29;
  localparam int CLR_BIT  = 28;
  localparam int EN_HI    = 27;
  localparam int EN_LO    = 26;
  localparam int CHIP_BIT = 0;

  typedef struct packed {
    logic             addr_reset;
    logic             store_en;
    logic [SEL_W-1:0] bank;
    logic             chip;
  } cmd_fields_t;

  function automatic cmd_fields_t split_cmd(input logic [CMD_W-1:0] w);
    cmd_fields_t f;
    f.addr_reset = w[CLR_BIT];
    f.store_en   = w[EN_HI] & w[EN_LO];
    f.bank       = w[SEL_LSB +: SEL_W];
    f.chip       = w[CHIP_BIT];
    return f;
  endfunction
endpackage

// File: rtl/cmd_decoder.sv
module cmd_decoder
  import codemem_pkg::*;
#(
  parameter int NUM_MEM = 8
) (
  input  logic               cmd_valid,
  input  logic [CMD_W-1:0]   cmd_word,
  input  logic               full,
  output logic               clr,
  output logic               adv,
  output logic               drop,
  output logic               chip,
  output logic [NUM_MEM-1:0] strobe
);
  cmd_fields_t f;

  always_comb begin
    f    = split_cmd(cmd_word);
    clr  = cmd_valid & f.addr_reset;
    adv  = cmd_valid & ~f.addr_reset & f.store_en & ~full;
    drop = cmd_valid & ~f.addr_reset & f.store_en & full;
    chip = f.chip;
  end

  for (genvar g = 0; g < NUM_MEM; g++) begin : g_strobe
    assign strobe[g] = adv & (f.bank == SEL_W'(g));
  end
endmodule

// File: rtl/addr_counter.sv
module addr_counter #(
  parameter int DEPTH = 256,
  localparam int CW   = $clog2(DEPTH + 1)
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          clr,
  input  logic          adv,
  input  logic          drop,
  output logic [CW-1:0] count,
  output logic          full,
  output logic          overflow
);
  assign full = (count == CW'(DEPTH));

  always_ff @(posedge clk) begin
    if (rst) begin
      count    <= '0;
      overflow <= 1'b0;
    end else begin
      if (clr)      count <= '0;
      else if (adv) count <= count + CW'(1);
      if (drop)     overflow <= 1'b1;
    end
  end

  AST_CLEAR_ZERO: assert property (@(posedge clk) disable iff (rst)
    clr |=> (count == '0)); // R2
  AST_STEP_ONE: assert property (@(posedge clk) disable iff (rst)
    adv |=> (count == $past(count) + CW'(1))); // R5
  AST_HOLD: assert property (@(posedge clk) disable iff (rst)
    (!clr && !adv) |=> $stable(count)); // R5
  AST_NO_OVERFLOW: assert property (@(posedge clk) disable iff (rst)
    count <= CW'(DEPTH)); // R7
  AST_STICKY: assert property (@(posedge clk) disable iff (rst)
    (overflow || drop) |=> overflow); // R7
endmodule

// File: rtl/code_bank.sv
module code_bank #(
  parameter int DEPTH = 256,
  localparam int AW   = $clog2(DEPTH)
) (
  input  logic          clk,
  input  logic          we,
  input  logic [AW-1:0] waddr,
  input  logic          wbit,
  input  logic [AW-1:0] raddr,
  output logic          rbit
);
  logic mem [DEPTH];

  always_ff @(posedge clk) begin
    if (we) mem[waddr] <= wbit;
    rbit <= mem[raddr];
  end
endmodule

// File: rtl/codemem_loader.sv
module codemem_loader
  import codemem_pkg::*;
#(
  parameter int NUM_MEM = 8,
  parameter int DEPTH   = 256,
  localparam int AW     = $clog2(DEPTH),
  localparam int CW     = $clog2(DEPTH + 1)
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             cmd_valid,
  input  logic [CMD_W-1:0] cmd_word,
  input  logic [SEL_W-1:0] rd_sel,
  input  logic [AW-1:0]    rd_addr,
  output logic             rd_data,
  output logic [CW-1:0]    addr_count,
  output logic             overflow
);
  logic               clr, adv, drop, chip, full;
  logic [NUM_MEM-1:0] strobe;
  logic [NUM_MEM-1:0] bank_q;
  logic [SEL_W-1:0]   sel_q;

  cmd_decoder #(.NUM_MEM(NUM_MEM)) u_dec (
    .cmd_valid(cmd_valid), .cmd_word(cmd_word), .full(full),
    .clr(clr), .adv(adv), .drop(drop), .chip(chip), .strobe(strobe)
  );

  addr_counter #(.DEPTH(DEPTH)) u_cnt (
    .clk(clk), .rst(rst), .clr(clr), .adv(adv), .drop(drop),
    .count(addr_count), .full(full), .overflow(overflow)
  );

  for (genvar b = 0; b < NUM_MEM; b++) begin : g_bank
    code_bank #(.DEPTH(DEPTH)) u_bank (
      .clk(clk), .we(strobe[b]), .waddr(addr_count[AW-1:0]), .wbit(chip),
      .raddr(rd_addr), .rbit(bank_q[b])
    );
  end

  always_ff @(posedge clk) begin
    if (rst) sel_q <= '0;
    else     sel_q <= rd_sel;
  end

  always_comb begin
    rd_data = 1'b0;
    for (int i = 0; i < NUM_MEM; i++)
      if (sel_q == SEL_W'(i)) rd_data = bank_q[i];
  end

  AST_ONE_STROBE: assert property (@(posedge clk) disable iff (rst)
    $onehot0(strobe)); // R8
  AST_CLEAR_WINS: assert property (@(posedge clk) disable iff (rst)
    (cmd_valid && cmd_word[CLR_BIT]) |-> (strobe == '0)); // R6
  AST_FULL_NO_WRITE: assert property (@(posedge clk) disable iff (rst)
    full |-> (strobe == '0)); // R7
endmodule

// File: tb/codemem_loader_bench.sv
`timescale 1ns/1ps
module codemem_loader_bench;
  localparam int NM = 8;
  localparam int DP = 16;
  localparam int AW = 4;
  localparam int CW = 5;

  logic clk = 1'b0;
  always #2 clk = ~clk;

  logic          rst, cmd_valid, rd_data, overflow;
  logic [31:0]   cmd_word;
  logic [2:0]    rd_sel;
  logic [AW-1:0] rd_addr;
  logic [CW-1:0] addr_count;

  codemem_loader #(.NUM_MEM(NM), .DEPTH(DP)) u_codemem_loader (
    .clk(clk), .rst(rst), .cmd_valid(cmd_valid), .cmd_word(cmd_word),
    .rd_sel(rd_sel), .rd_addr(rd_addr), .rd_data(rd_data),
    .addr_count(addr_count), .overflow(overflow)
  );

  int total = 0;
  int bad = 0;
  bit done = 0;
  bit mm [NM][DP];
  bit mk [NM][DP];
  int m_cnt = 0;
  bit m_ovf = 0;

  task automatic chk(input string tag, input string what, input int act, input int exp);
    total++;
    if (act != exp) begin
      bad++;
      $display("FAIL %s %s actual=%0d expected=%0d t=%0t", tag, what, act, exp, $time);
    end
  endtask

  function automatic logic [31:0] wr(input int s, input bit b);
    logic [2:0] s3 = s[2:0];
    return {s3, 1'b0, 2'b11, 25'b0, b};
  endfunction

  function automatic logic [31:0] clr(input int s);
    logic [2:0] s3 = s[2:0];
    return {s3, 1'b1, 28'b0};
  endfunction

  // one clock: drive, update model, compare after the edge
  task automatic step(input bit v, input logic [31:0] w, input int rs, input int ra,
                      input string tag);
    bit ek;
    int er;
    int b;
    @(negedge clk);
    cmd_valid = v; cmd_word = w; rd_sel = rs[2:0]; rd_addr = ra[AW-1:0];
    ek = mk[rs][ra];
    er = mm[rs][ra];
    if (v) begin
      if (w[28]) m_cnt = 0;
      else if (w[27] && w[26]) begin
        if (m_cnt >= DP) m_ovf = 1;
        else begin
          b = int'(w[31:29]);
          mm[b][m_cnt] = w[0];
          mk[b][m_cnt] = 1;
          m_cnt++;
        end
      end
    end
    @(posedge clk);
    #1;
    chk(tag, "addr_count", int'(addr_count), m_cnt);
    chk(tag, "overflow", int'(overflow), int'(m_ovf));
    if (ek) chk(tag, "rd_data", int'(rd_data), er);
  endtask

  function automatic bit pat(input int s, input int k);
    return bit'(((s * 5 + k * 3 + k / 4) % 7) & 1);
  endfunction

  initial begin
    #(4 * 20000);
    if (!done) begin
      total++; bad++;
      $display("FAIL watchdog expired");
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    rst = 1; cmd_valid = 0; cmd_word = '0; rd_sel = '0; rd_addr = '0;
    repeat (4) @(negedge clk);
    rst = 0;
    #1;
    chk("R1", "addr_count", int'(addr_count), 0);
    chk("R1", "overflow", int'(overflow), 0);

    // R2 R4 R5: normal load of every correlator, reading the previous bank
    for (int s = 0; s < NM; s++) begin
      step(1, clr(s), (s + NM - 1) % NM, 0, "R2");
      for (int k = 0; k < DP; k++) begin
        step(1, wr(s, pat(s, k)), (s + NM - 1) % NM, k, "R4");
        if (k == 5) step(0, wr(s, 1), s, 0, "R5");
      end
    end
    for (int s = 0; s < NM; s++)
      for (int k = 0; k < DP; k++) step(0, '0, s, k, "R4");

    // R7: store when counter is at depth
    step(1, wr(3, ~pat(3, 0)), 3, 0, "R7");
    step(1, wr(0, 1), 0, DP - 1, "R7");
    step(1, clr(0), 0, 0, "R7");
    step(0, '0, 0, 0, "R7");

    // R3: only one enable bit set
    step(1, 32'h0800_0001 | (32'h2 << 29), 2, 0, "R3");
    step(1, 32'h0400_0001 | (32'h2 << 29), 2, 0, "R3");
    step(1, 32'h0800_0000, 0, 0, "R3");
    step(0, '0, 2, 0, "R3");

    // R4: read-first when reading the location being written
    step(1, wr(1, ~pat(1, 0)), 1, 0, "R4");
    step(0, '0, 1, 0, "R4");
    step(1, wr(1, ~pat(1, 1)), 1, 1, "R4");
    step(1, wr(1, ~pat(1, 2)), 1, 1, "R4");

    // R6: reset together with store
    step(1, 32'h1C00_0001 | (32'h1 << 29), 1, 3, "R6");
    step(1, 32'h1C00_0000 | (32'h1 << 29), 1, 0, "R6");
    step(0, '0, 1, 0, "R6");

    // R8: reload bank 2 with inverted data, sweep the others
    step(1, clr(2), 2, 0, "R8");
    for (int k = 0; k < DP; k++) step(1, wr(2, ~pat(2, k)), 2, k, "R8");
    for (int s = 0; s < NM; s++)
      for (int k = 0; k < DP; k++) step(0, '0, s, k, "R8");

    // R5: idle cycles hold the counter
    step(1, clr(0), 0, 0, "R5");
    step(1, wr(0, 1), 0, 0, "R5");
    for (int i = 0; i < 4; i++) step(0, wr(0, 0), 0, 0, "R5");

    done = 1;
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule